// File: doc/BRIEF.md
# Dual-Port Word Memory with Collision Arbitration

This block is a synchronous dual-port memory of 4096 words of 16 bits with two identical, independent ports, named left and right. Each port has a chip enable, a write strobe, two byte enables, an address, write data and registered read data. When both ports select the same word, an arbiter picks one owner. The other port gets an active-low busy indication, and its writes are suppressed. That port's reads still complete.

The arbiter looks only at chip enables and addresses. A read against a read is treated the same as a write against a write. Each port's request is registered at the first clock edge, and the arbiter updates its state at that same edge. The write is committed at the second edge and is gated by the registered owner. Busy is therefore valid one cycle after the address is presented, in the same cycle that the write is gated. A mode pin sets the role of the part. In master mode it drives busy. In slave mode it ignores its own arbitration and takes a busy input per port, which only inhibits writes. This lets a wide word be split across one master and several slaves that follow its decision.

The arbiter is a three-state machine. IDLE means no collision. LEFT_OWNS means the right port is busy. RIGHT_OWNS means the left port is busy. The transitions are as follows. IDLE goes to LEFT_OWNS on a new collision, unless only the right port held the word in the previous cycle, in which case it goes to RIGHT_OWNS. LEFT_OWNS stays while the left port keeps the same enabled address. RIGHT_OWNS stays while the right port keeps the same enabled address. An owner that moves away hands the word to the other port if the collision persists. Any state returns to IDLE when the collision clears.

Top module: `dpram_busy_arb`

## Requirements
- R1: A write presented in cycle c changes only the bytes whose enable is set: bit 0 is bits 7:0 and bit 1 is bits 15:8. It is committed at the second rising edge after presentation. A read presented in cycle c shows the stored word on rdata after the second rising edge, with the value that held before any write committed at that same edge.
- R2: Accesses to different addresses never raise busy. Writes from both ports in the same cycle to different addresses are both stored.
- R3: Busy is decided from chip enables and addresses only, so two enabled reads of the same address also raise busy.
- R4: Busy outputs are active low. They assert in the cycle after the collision is presented and return high in the cycle after it clears.
- R5: When both ports newly select the same address in the same cycle, the left port wins and the right busy goes low.
- R6: A port that was already enabled at the collided address in the previous cycle keeps ownership while it stays there. The other port is marked busy.
- R7: During a collision in master mode, the owner's write is stored and the busy port's write is dropped.
- R8: A busy port still returns correct read data.
- R9: With master_mode low, both busy outputs stay high. A low busy input blocks all writes on its port, and a high busy input allows them.
- R10: While rst_n is low, both rdata outputs are zero and both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = drive busy, 0 = take busy as write inhibit |
| l_ce | input | 1 | Left chip enable |
| l_we | input | 1 | Left write strobe |
| l_be | input | 2 | Left byte enables |
| l_addr | input | 12 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| l_busy_n_o | output | 1 | Left busy, active low (master mode) |
| l_busy_n_i | input | 1 | Left write inhibit, active low (slave mode) |
| r_ce | input | 1 | Right chip enable |
| r_we | input | 1 | Right write strobe |
| r_be | input | 2 | Right byte enables |
| r_addr | input | 12 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_busy_n_o | output | 1 | Right busy, active low (master mode) |
| r_busy_n_i | input | 1 | Right write inhibit, active low (slave mode) |

## Verification
The ownership properties compare each port's current address and enable with the previous cycle's values through $past. They therefore take for granted that both chip enables are held low for the whole reset, so that the internal request registers and the sampled history agree at the first active edge. The properties also assume that master_mode changes only between sequences, never in the middle of a collision. The stimulus keeps both enables low during reset and switches the mode only while both ports are idle. It applies every input change at the falling clock edge, so each address and enable is settled a full half cycle before the edge that registers it.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
    localparam int NUM_PORTS = 2;
    localparam int P_LEFT    = 0;
    localparam int P_RIGHT   = 1;

    typedef enum logic [1:0] {
        ARB_IDLE       = 2'd0,
        ARB_LEFT_OWNS  = 2'd1,
        ARB_RIGHT_OWNS = 2'd2
    } arb_state_e;
endpackage

// File: rtl/dpram_req_reg.sv
`timescale 1ns/1ps
module dpram_req_reg #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_d,
    input  logic              we_d,
    input  logic [BE_W-1:0]   be_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [DATA_W-1:0] wdata_d,
    output logic              ce_q,
    output logic              we_q,
    output logic [BE_W-1:0]   be_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q    <= 1'b0;
            we_q    <= 1'b0;
            be_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            ce_q    <= ce_d;
            we_q    <= we_d;
            be_q    <= be_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end
endmodule

// File: rtl/dpram_arbiter.sv
`timescale 1ns/1ps
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS-1:0]           ce_now,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_now,
    input  logic [NUM_PORTS-1:0]           ce_prev,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_prev,
    output logic [NUM_PORTS-1:0]           lose
);
    arb_state_e state_q, state_d;
    logic                 hit;
    logic [NUM_PORTS-1:0] held;

    assign hit = ce_now[P_LEFT] && ce_now[P_RIGHT] &&
                 (addr_now[P_LEFT] == addr_now[P_RIGHT]);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_held
        assign held[p] = ce_prev[p] && (addr_prev[p] == addr_now[p]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ARB_IDLE;
        unique case (state_q)
            ARB_IDLE: begin
                if (hit)
                    state_d = (held[P_RIGHT] && !held[P_LEFT]) ? ARB_RIGHT_OWNS
                                                               : ARB_LEFT_OWNS;
            end
            ARB_LEFT_OWNS: begin
                if (hit)
                    state_d = (!held[P_LEFT] && held[P_RIGHT]) ? ARB_RIGHT_OWNS
                                                               : ARB_LEFT_OWNS;
            end
            ARB_RIGHT_OWNS: begin
                if (hit)
                    state_d = held[P_RIGHT] ? ARB_RIGHT_OWNS : ARB_LEFT_OWNS;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        lose          = '0;
        lose[P_LEFT]  = (state_q == ARB_RIGHT_OWNS);
        lose[P_RIGHT] = (state_q == ARB_LEFT_OWNS);
    end
endmodule

// File: rtl/dpram_store.sv
`timescale 1ns/1ps
module dpram_store
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             rd_en,
    input  logic [NUM_PORTS-1:0]             wr_en,
    input  logic [NUM_PORTS-1:0][BE_W-1:0]   be,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / BE_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_en[p] && be[p][b])
                    cells[addr[p]][b*LANE_W +: LANE_W] <= wdata[p][b*LANE_W +: LANE_W];
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n)        rdata[p] <= '0;
            else if (rd_en[p]) rdata[p] <= cells[addr[p]];
        end
    end
endmodule

// File: rtl/dpram_busy_arb.sv
`timescale 1ns/1ps
module dpram_busy_arb
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_ce,
    input  logic              l_we,
    input  logic [BE_W-1:0]   l_be,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_busy_n_o,
    input  logic              l_busy_n_i,
    input  logic              r_ce,
    input  logic              r_we,
    input  logic [BE_W-1:0]   r_be,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_busy_n_o,
    input  logic              r_busy_n_i
);
    logic [NUM_PORTS-1:0]             ce_d, we_d, busy_in_n;
    logic [NUM_PORTS-1:0][BE_W-1:0]   be_d;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_d;
    logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_d;

    logic [NUM_PORTS-1:0]             ce_q, we_q, lose, inhibit, wr_en;
    logic [NUM_PORTS-1:0][BE_W-1:0]   be_q;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_q;
    logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_q, rdata;

    assign ce_d      = {r_ce, l_ce};
    assign we_d      = {r_we, l_we};
    assign be_d      = {r_be, l_be};
    assign addr_d    = {r_addr, l_addr};
    assign wdata_d   = {r_wdata, l_wdata};
    assign busy_in_n = {r_busy_n_i, l_busy_n_i};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpram_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) req_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce_d    (ce_d[p]),
            .we_d    (we_d[p]),
            .be_d    (be_d[p]),
            .addr_d  (addr_d[p]),
            .wdata_d (wdata_d[p]),
            .ce_q    (ce_q[p]),
            .we_q    (we_q[p]),
            .be_q    (be_q[p]),
            .addr_q  (addr_q[p]),
            .wdata_q (wdata_q[p])
        );
        // Registered owner gates the write committed this cycle.
        assign inhibit[p] = master_mode ? lose[p] : !busy_in_n[p];
        assign wr_en[p]   = ce_q[p] && we_q[p] && !inhibit[p];
    end

    dpram_arbiter #(.ADDR_W(ADDR_W)) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_now    (ce_d),
        .addr_now  (addr_d),
        .ce_prev   (ce_q),
        .addr_prev (addr_q),
        .lose      (lose)
    );

    dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (ce_q),
        .wr_en (wr_en),
        .be    (be_q),
        .addr  (addr_q),
        .wdata (wdata_q),
        .rdata (rdata)
    );

    assign l_rdata    = rdata[P_LEFT];
    assign r_rdata    = rdata[P_RIGHT];
    assign l_busy_n_o = !(master_mode && lose[P_LEFT]);
    assign r_busy_n_o = !(master_mode && lose[P_RIGHT]);
endmodule

// File: rtl/dpram_busy_arb_chk.sv
`timescale 1ns/1ps
module dpram_busy_arb_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              l_ce,
    input logic              r_ce,
    input logic [ADDR_W-1:0] l_addr,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_n_o,
    input logic              r_busy_n_o
);
    // R4
    busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n_o && !r_busy_n_o));

    // R2
    no_busy_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_ce && r_ce && (l_addr == r_addr)) |=> (l_busy_n_o && r_busy_n_o));

    // R5
    left_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && l_ce && r_ce && (l_addr == r_addr) &&
         !($past(l_ce) && ($past(l_addr) == l_addr)) &&
         !($past(r_ce) && ($past(r_addr) == r_addr)))
        |=> (!r_busy_n_o && l_busy_n_o));

    // R6
    left_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !r_busy_n_o && l_ce && r_ce && (l_addr == r_addr) &&
         (l_addr == $past(l_addr)))
        |=> !r_busy_n_o);

    // R6
    right_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !l_busy_n_o && l_ce && r_ce && (l_addr == r_addr) &&
         (r_addr == $past(r_addr)))
        |=> !l_busy_n_o);
endmodule

bind dpram_busy_arb dpram_busy_arb_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dpram_busy_arb_tb.sv
`timescale 1ns/1ps
module dpram_busy_arb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_mode = 1'b1;
    logic        l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
    logic [1:0]  l_be = 0, r_be = 0;
    logic [11:0] l_addr = 0, r_addr = 0;
    logic [15:0] l_wdata = 0, r_wdata = 0;
    logic [15:0] l_rdata, r_rdata;
    logic        l_busy_n_o, r_busy_n_o;
    logic        l_busy_n_i = 1'b1, r_busy_n_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dpram_busy_arb dut_i (.*);

    typedef struct packed {
        logic        lce;
        logic [11:0] la;
        logic        rce;
        logic [11:0] ra;
        logic        elb;
        logic        erb;
        logic [3:0]  req;
    } vec_t;

    // All reads: busy follows address and enable only (R3).
    localparam vec_t VECS [11] = '{
        '{1'b1, 12'd10, 1'b1, 12'd20, 1'b1, 1'b1, 4'd2},  // R2 apart
        '{1'b1, 12'd30, 1'b1, 12'd30, 1'b1, 1'b0, 4'd5},  // R5 both new
        '{1'b1, 12'd30, 1'b1, 12'd30, 1'b1, 1'b0, 4'd6},  // R6 left held
        '{1'b0, 12'd30, 1'b1, 12'd30, 1'b1, 1'b1, 4'd4},  // R4 release
        '{1'b1, 12'd40, 1'b1, 12'd41, 1'b1, 1'b1, 4'd2},
        '{1'b1, 12'd40, 1'b1, 12'd40, 1'b1, 1'b0, 4'd6},  // left was there
        '{1'b1, 12'd50, 1'b1, 12'd40, 1'b1, 1'b1, 4'd4},
        '{1'b1, 12'd40, 1'b1, 12'd40, 1'b0, 1'b1, 4'd6},  // right was there
        '{1'b1, 12'd40, 1'b1, 12'd40, 1'b0, 1'b1, 4'd6},
        '{1'b1, 12'd40, 1'b0, 12'd40, 1'b1, 1'b1, 4'd4},
        '{1'b0, 12'd40, 1'b0, 12'd40, 1'b1, 1'b1, 4'd4}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        l_ce = 0; l_we = 0; r_ce = 0; r_we = 0;
    endtask

    task automatic drive(input bit port, input bit we, input logic [11:0] a,
                         input logic [15:0] d, input logic [1:0] be);
        if (port == 0) begin
            l_ce = 1; l_we = we; l_addr = a; l_wdata = d; l_be = be;
        end else begin
            r_ce = 1; r_we = we; r_addr = a; r_wdata = d; r_be = be;
        end
    endtask

    task automatic wr(input bit port, input logic [11:0] a, input logic [15:0] d,
                      input logic [1:0] be);
        @(negedge clk); drive(port, 1'b1, a, d, be);
        @(negedge clk); idle();
    endtask

    task automatic rd(input bit port, input logic [11:0] a, output logic [15:0] d);
        @(negedge clk); drive(port, 1'b0, a, 16'h0, 2'b00);
        @(negedge clk); idle();
        @(negedge clk); d = port ? r_rdata : l_rdata;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R10 reset values
        check("R10 l_rdata", l_rdata, 0);
        check("R10 r_rdata", r_rdata, 0);
        check("R10 busy", {l_busy_n_o, r_busy_n_o}, 2'b11);
        rst_n = 1'b1;

        // Arbitration table
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            if (i > 0)
                check($sformatf("R%0d/R3 vec %0d", VECS[i-1].req, i - 1),
                      {l_busy_n_o, r_busy_n_o}, {VECS[i-1].elb, VECS[i-1].erb});
            l_ce = VECS[i].lce; l_addr = VECS[i].la; l_we = 0;
            r_ce = VECS[i].rce; r_addr = VECS[i].ra; r_we = 0;
        end
        @(negedge clk);
        check("R4 vec 10", {l_busy_n_o, r_busy_n_o}, {VECS[10].elb, VECS[10].erb});
        idle();

        // R1 byte enables
        wr(0, 12'd5, 16'hABCD, 2'b11);
        wr(0, 12'd5, 16'h1234, 2'b01);
        rd(1, 12'd5, v); check("R1 low lane", v, 16'hAB34);
        wr(1, 12'd5, 16'h9900, 2'b10);
        rd(0, 12'd5, v); check("R1 high lane", v, 16'h9934);

        // R2 simultaneous writes, different addresses
        @(negedge clk);
        drive(0, 1, 12'd100, 16'h1111, 2'b11);
        drive(1, 1, 12'd200, 16'h2222, 2'b11);
        @(negedge clk);
        check("R2 busy", {l_busy_n_o, r_busy_n_o}, 2'b11);
        idle();
        rd(0, 12'd200, v); check("R2 right data", v, 16'h2222);
        rd(1, 12'd100, v); check("R2 left data", v, 16'h1111);

        // R7 both new: left stored, right dropped
        @(negedge clk);
        drive(0, 1, 12'd300, 16'hC0DE, 2'b11);
        drive(1, 1, 12'd300, 16'hBAD0, 2'b11);
        @(negedge clk);
        check("R7 busy", {l_busy_n_o, r_busy_n_o}, 2'b10);
        idle();
        rd(1, 12'd300, v); check("R7 winner left", v, 16'hC0DE);

        // R7 with R6: right held the word first
        @(negedge clk); drive(1, 1, 12'd301, 16'hAAAA, 2'b11);
        @(negedge clk);
        drive(1, 1, 12'd301, 16'hBBBB, 2'b11);
        drive(0, 1, 12'd301, 16'hCCCC, 2'b11);
        @(negedge clk); idle();
        check("R6 left busy", {l_busy_n_o, r_busy_n_o}, 2'b01);
        rd(0, 12'd301, v); check("R7 winner right", v, 16'hBBBB);

        // R8 busy port still reads (old value, read before same-edge write)
        @(negedge clk);
        drive(0, 1, 12'd300, 16'h5555, 2'b11);
        drive(1, 0, 12'd300, 16'h0000, 2'b00);
        @(negedge clk); idle();
        check("R8 right busy", r_busy_n_o, 1'b0);
        @(negedge clk);
        check("R8 loser read", r_rdata, 16'hC0DE);
        rd(1, 12'd300, v); check("R7 owner write", v, 16'h5555);

        // R9 slave mode
        @(negedge clk); master_mode = 1'b0;
        wr(0, 12'd400, 16'h1111, 2'b11);
        @(negedge clk);
        l_busy_n_i = 1'b0;
        drive(0, 1, 12'd400, 16'h7777, 2'b11);
        drive(1, 0, 12'd400, 16'h0000, 2'b00);
        @(negedge clk); idle();
        check("R9 outputs high", {l_busy_n_o, r_busy_n_o}, 2'b11);
        @(negedge clk); l_busy_n_i = 1'b1;
        rd(0, 12'd400, v); check("R9 inhibit", v, 16'h1111);
        wr(1, 12'd401, 16'h4242, 2'b11);
        rd(0, 12'd401, v); check("R9 allowed", v, 16'h4242);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule